// File: doc/BRIEF.md
# Integer Add/Subtract and Compare Unit with Flag Recording

This block is the add, subtract-from and compare slice of a 32-bit integer execution pipe. Each cycle with `valid` high it takes two operands, or the first operand and a 16-bit immediate, and runs one operation from the add or subtract-from families or a compare. It keeps a carry flag, an overflow flag and a sticky summary-overflow flag in a small status register. The extended forms read the stored carry as their carry-in and write the new carry back. This lets a wide add or subtract be split into 32-bit pieces that chain through the flag.

The overflow-enable input lets an arithmetic operation update the overflow flag and, through it, the sticky summary flag. The record-enable input loads a 4-bit condition field. It is built from the sign of the result, or from the compare outcome, and its low bit is a copy of the summary flag. A dedicated opcode clears all three flags. Result, flags and condition field are registered and can be read in the cycle after the operation is issued.

Top module: `arith_flag_unit`

## Requirements
- R1: While `rst` is high on a clock edge, `result`, `resValid`, `flagWord` and `condField` become zero.
- R2: Add opcodes (`opSel` 0 plain, 1 carrying) produce `result` = A + Y, where Y is `opB`, or the immediate when `useImm` is set.
- R3: Subtract-from opcodes (5 plain, 6 carrying) produce Y + ~A + 1, which is Y minus A. The carrying form sets carry when no borrow occurs, that is when Y >= A unsigned.
- R4: Extended opcodes use the stored carry as the carry-in and write back the carry-out. Opcode 2 computes A+Y+CA and opcode 7 computes Y+~A+CA. Opcodes 3 and 8 replace Y with all-ones. Opcodes 4 and 9 replace Y with zero. The subtract forms (7, 8, 9) use ~A.
- R5: Plain opcodes 0 and 5 leave the carry flag unchanged. Opcodes 1 to 4 and 6 to 9 write the carry-out to it.
- R6: With `ovEnable` high, an arithmetic opcode that overflows as signed sets OV and SO, and one that does not overflow clears OV and leaves SO unchanged. Signed overflow means the two adder inputs share a sign bit and the sum's sign differs from it. With `ovEnable` low, OV and SO are unchanged.
- R7: Once set, SO stays set until the clear opcode or reset.
- R8: Opcode 10 is a signed compare and opcode 11 an unsigned compare of A against Y. `result` becomes 8 (A<Y), 4 (A>Y) or 2 (equal) with all other bits zero. Flags are unchanged.
- R9: With `recEnable` high on an arithmetic or compare opcode, `condField[3:1]` becomes 100 for a negative result, 010 for a positive one and 001 for zero. For a compare it takes the compare code instead. `condField[0]` takes SO as updated by that same operation. With `recEnable` low, `condField` holds its value.
- R10: Opcode 12 clears SO, OV and CA together. `flagWord` packs SO in bit 3, OV in bit 2 and CA in bit 1, with bit 0 always 0.
- R11: With `useImm` set, the 16-bit immediate replaces `opB`. It is sign-extended for every opcode except the unsigned compare, which zero-extends it.
- R12: With `valid` low, or with opcodes 13 to 15, flags, `result` and `condField` keep their values and `resValid` is low.
- R13: All outputs change on the clock edge that samples the operation. `resValid` is high in the following cycle exactly when an arithmetic or compare opcode was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Issue strobe for the operation on the inputs |
| opSel | input | 4 | Operation select (codes in R2 to R12) |
| opA | input | 32 | First operand A |
| opB | input | 32 | Second operand |
| imm | input | 16 | Immediate that replaces `opB` when `useImm` is set |
| useImm | input | 1 | Use the extended immediate as the second operand |
| ovEnable | input | 1 | Let the operation update OV and SO |
| recEnable | input | 1 | Load the condition field |
| result | output | 32 | Registered sum, difference or compare code |
| resValid | output | 1 | A result was produced by the previous edge |
| flagWord | output | 4 | {SO, OV, CA, 0} |
| condField | output | 4 | Recorded condition field |

## Verification
A wrong carry, overflow or summary flag does not always show at once. A corrupted CA surfaces only at the next extended or carrying operation, where the result is off by one. A wrong SO shows directly on `flagWord` in the next cycle, and on the low bit of `condField` at the next recorded operation. A reference model in the bench tracks the three flags on every cycle and compares them after every edge. Operand corners 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF are swept through every opcode in turn, so a stale or mis-chained carry shows up within one operation.

// File: rtl/arith_pkg.sv
package arith_pkg;

  typedef enum logic [3:0] {
    OP_ADD        = 4'd0,
    OP_ADD_CY     = 4'd1,
    OP_ADD_EXT    = 4'd2,
    OP_ADD_M1_EXT = 4'd3,
    OP_ADD_Z_EXT  = 4'd4,
    OP_RSUB       = 4'd5,
    OP_RSUB_CY    = 4'd6,
    OP_RSUB_EXT   = 4'd7,
    OP_RSUB_M1    = 4'd8,
    OP_RSUB_Z     = 4'd9,
    OP_CMP_S      = 4'd10,
    OP_CMP_U      = 4'd11,
    OP_FLAG_CLR   = 4'd12
  } arithOp_e;

  typedef enum logic [1:0] {
    Y_OPND = 2'd0,
    Y_ONES = 2'd1,
    Y_ZERO = 2'd2
  } ySel_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_CA   = 2'd2
  } cinSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    fire;      // write result, raise resValid
    logic    invX;      // subtract-from: invert operand A
    ySel_e   ySel;
    cinSel_e cinSel;
    logic    wrCa;
    logic    wrOv;
    logic    isCmp;
    logic    cmpSigned;
    logic    useImm;
    logic    immZext;
    logic    clrFlags;
    logic    wrCond;
  } ctrlStrobe_t;

  localparam logic [3:0] CC_NEG  = 4'b1000;
  localparam logic [3:0] CC_POS  = 4'b0100;
  localparam logic [3:0] CC_ZERO = 4'b0010;

endpackage

// File: rtl/arith_ctrl.sv
module arith_ctrl
  import arith_pkg::*;
(
  input  logic        valid,
  input  logic [3:0]  opSel,
  input  logic        useImm,
  input  logic        ovEnable,
  input  logic        recEnable,
  output ctrlStrobe_t strb
);

  logic isArith;

  always_comb begin
    strb    = '0;
    isArith = 1'b0;
    if (valid) begin
      unique case (arithOp_e'(opSel))
        OP_ADD:        begin isArith = 1'b1; strb.ySel = Y_OPND; strb.cinSel = CIN_ZERO; end
        OP_ADD_CY:     begin isArith = 1'b1; strb.ySel = Y_OPND; strb.cinSel = CIN_ZERO; strb.wrCa = 1'b1; end
        OP_ADD_EXT:    begin isArith = 1'b1; strb.ySel = Y_OPND; strb.cinSel = CIN_CA;   strb.wrCa = 1'b1; end
        OP_ADD_M1_EXT: begin isArith = 1'b1; strb.ySel = Y_ONES; strb.cinSel = CIN_CA;   strb.wrCa = 1'b1; end
        OP_ADD_Z_EXT:  begin isArith = 1'b1; strb.ySel = Y_ZERO; strb.cinSel = CIN_CA;   strb.wrCa = 1'b1; end
        OP_RSUB:       begin isArith = 1'b1; strb.invX = 1'b1; strb.ySel = Y_OPND; strb.cinSel = CIN_ONE; end
        OP_RSUB_CY:    begin isArith = 1'b1; strb.invX = 1'b1; strb.ySel = Y_OPND; strb.cinSel = CIN_ONE; strb.wrCa = 1'b1; end
        OP_RSUB_EXT:   begin isArith = 1'b1; strb.invX = 1'b1; strb.ySel = Y_OPND; strb.cinSel = CIN_CA;  strb.wrCa = 1'b1; end
        OP_RSUB_M1:    begin isArith = 1'b1; strb.invX = 1'b1; strb.ySel = Y_ONES; strb.cinSel = CIN_CA;  strb.wrCa = 1'b1; end
        OP_RSUB_Z:     begin isArith = 1'b1; strb.invX = 1'b1; strb.ySel = Y_ZERO; strb.cinSel = CIN_CA;  strb.wrCa = 1'b1; end
        OP_CMP_S:      begin strb.isCmp = 1'b1; strb.cmpSigned = 1'b1; end
        OP_CMP_U:      begin strb.isCmp = 1'b1; strb.immZext = 1'b1; end
        OP_FLAG_CLR:   strb.clrFlags = 1'b1;
        default:       strb = '0;
      endcase
      strb.fire   = isArith | strb.isCmp;
      strb.wrOv   = isArith & ovEnable;
      strb.wrCond = (isArith | strb.isCmp) & recEnable;
      strb.useImm = useImm & (isArith | strb.isCmp);
    end
  end

endmodule

// File: rtl/arith_addcore.sv
module arith_addcore #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    // Like-signed inputs whose sum flips sign overflow as signed values
    ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end

endmodule

// File: rtl/arith_cmp.sv
module arith_cmp
  import arith_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         signedMode,
  output logic [3:0]   code
);

  logic isLess;
  logic isEq;

  always_comb begin
    isEq   = (a == b);
    isLess = signedMode ? ($signed(a) < $signed(b)) : (a < b);
    if (isLess)      code = CC_NEG;
    else if (isEq)   code = CC_ZERO;
    else             code = CC_POS;
  end

endmodule

// File: rtl/arith_datapath.sv
module arith_datapath
  import arith_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strb,
  input  logic [W-1:0]     opA,
  input  logic [W-1:0]     opB,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     result,
  output logic             resValid,
  output logic [3:0]       flagWord,
  output logic [3:0]       condField
);

  localparam int PAD_W = W - 4;

  logic [W-1:0] immExt;
  logic [W-1:0] srcB;
  logic [W-1:0] xIn;
  logic [W-1:0] yIn;
  logic [W-1:0] sumOut;
  logic         cinBit;
  logic         coutBit;
  logic         ovfBit;
  logic [3:0]   cmpCode;
  logic [3:0]   signCode;
  logic         soQ, ovQ, caQ;
  logic         soNext, ovNext, caNext;
  logic [W-1:0] resNext;
  logic [3:0]   condNext;

  generate
    if (IMM_W < W) begin : g_immExtend
      assign immExt = strb.immZext ? {{(W-IMM_W){1'b0}}, imm}
                                   : {{(W-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_immTrunc
      assign immExt = imm[W-1:0];
    end
  endgenerate

  always_comb begin
    srcB = strb.useImm ? immExt : opB;
    xIn  = strb.invX ? ~opA : opA;
    unique case (strb.ySel)
      Y_ONES:  yIn = '1;
      Y_ZERO:  yIn = '0;
      default: yIn = srcB;
    endcase
    unique case (strb.cinSel)
      CIN_ONE: cinBit = 1'b1;
      CIN_CA:  cinBit = caQ;
      default: cinBit = 1'b0;
    endcase
  end

  arith_addcore #(.W(W)) u_addcore (
    .x   (xIn),
    .y   (yIn),
    .cin (cinBit),
    .sum (sumOut),
    .cout(coutBit),
    .ovf (ovfBit)
  );

  arith_cmp #(.W(W)) u_cmp (
    .a         (opA),
    .b         (srcB),
    .signedMode(strb.cmpSigned),
    .code      (cmpCode)
  );

  always_comb begin
    if (sumOut[W-1])      signCode = CC_NEG;
    else if (sumOut == '0) signCode = CC_ZERO;
    else                  signCode = CC_POS;

    caNext = strb.wrCa ? coutBit : caQ;
    ovNext = strb.wrOv ? ovfBit : ovQ;
    soNext = soQ | (strb.wrOv & ovfBit);
    if (strb.clrFlags) begin
      caNext = 1'b0;
      ovNext = 1'b0;
      soNext = 1'b0;
    end

    resNext  = strb.isCmp ? {{PAD_W{1'b0}}, cmpCode} : sumOut;
    condNext = strb.isCmp ? {cmpCode[3:1], soNext} : {signCode[3:1], soNext};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soQ       <= 1'b0;
      ovQ       <= 1'b0;
      caQ       <= 1'b0;
      result    <= '0;
      resValid  <= 1'b0;
      condField <= '0;
    end else begin
      soQ      <= soNext;
      ovQ      <= ovNext;
      caQ      <= caNext;
      resValid <= strb.fire;
      if (strb.fire)   result    <= resNext;
      if (strb.wrCond) condField <= condNext;
    end
  end

  assign flagWord = {soQ, ovQ, caQ, 1'b0};

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import arith_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic              useImm,
  input  logic              ovEnable,
  input  logic              recEnable,
  output logic [DATA_W-1:0] result,
  output logic              resValid,
  output logic [3:0]        flagWord,
  output logic [3:0]        condField
);

  ctrlStrobe_t strb;

  arith_ctrl u_ctrl (
    .valid    (valid),
    .opSel    (opSel),
    .useImm   (useImm),
    .ovEnable (ovEnable),
    .recEnable(recEnable),
    .strb     (strb)
  );

  arith_datapath #(.W(DATA_W), .IMM_W(IMM_W)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .imm      (imm),
    .result   (result),
    .resValid (resValid),
    .flagWord (flagWord),
    .condField(condField)
  );

endmodule

// File: rtl/arith_flag_unit_chk.sv
module arith_flag_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              valid,
  input logic [3:0]        opSel,
  input logic              ovEnable,
  input logic [DATA_W-1:0] result,
  input logic              resValid,
  input logic [3:0]        flagWord,
  input logic [3:0]        condField
);

  // OV set always comes with SO set; only clear/reset drop SO
  assert_ov_implies_so_R6: assert property (@(posedge clk) disable iff (rst)
    flagWord[2] |-> flagWord[3]);

  assert_no_ov_change_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && !ovEnable && opSel != 4'd12) |=> $stable(flagWord[3:2]));

  assert_so_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flagWord[3] && !(valid && opSel == 4'd12)) |=> flagWord[3]);

  assert_plain_keeps_ca_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && (opSel == 4'd0 || opSel == 4'd5)) |=> $stable(flagWord[1]));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (valid && opSel == 4'd12) |=> (flagWord == 4'b0000));

  assert_cmp_code_R8: assert property (@(posedge clk) disable iff (rst)
    (valid && (opSel == 4'd10 || opSel == 4'd11)) |=>
      (result[DATA_W-1:4] == '0 && result[0] == 1'b0 && $countones(result[3:1]) == 1));

  assert_cond_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(condField[3:1]));

  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (!resValid && $stable(flagWord) && $stable(result) && $stable(condField)));

endmodule

bind arith_flag_unit arith_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .valid    (valid),
  .opSel    (opSel),
  .ovEnable (ovEnable),
  .result   (result),
  .resValid (resValid),
  .flagWord (flagWord),
  .condField(condField)
);

// File: tb/tb_arith_flag_unit.sv
`timescale 1ns/1ps
module tb_arith_flag_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] imm = '0;
  logic        useImm = 1'b0;
  logic        ovEnable = 1'b0;
  logic        recEnable = 1'b0;
  logic [31:0] result;
  logic        resValid;
  logic [3:0]  flagWord;
  logic [3:0]  condField;

  int testsRun = 0;
  int testsFailed = 0;

  // reference state
  logic        mSo = 0, mOv = 0, mCa = 0, mResValid = 0;
  logic [31:0] mRes = '0;
  logic [3:0]  mCond = '0;
  string       flagTag = "R1";

  logic [31:0] corners [5] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

  arith_flag_unit dut (
    .clk(clk), .rst(rst), .valid(valid), .opSel(opSel), .opA(opA), .opB(opB),
    .imm(imm), .useImm(useImm), .ovEnable(ovEnable), .recEnable(recEnable),
    .result(result), .resValid(resValid), .flagWord(flagWord), .condField(condField)
  );

  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] codeOf(longint v);
    if (v < 0) return 4'b1000;
    if (v > 0) return 4'b0100;
    return 4'b0010;
  endfunction

  function automatic string resTag(int op);
    if (useImm) return "R11";
    if (op == 0 || op == 1) return "R2";
    if (op == 5 || op == 6) return "R3";
    if (op >= 2 && op <= 9) return "R4";
    if (op == 10 || op == 11) return "R8";
    return "R12";
  endfunction

  // Behavioural update from the inputs present at the clock edge
  task automatic modelUpdate();
    int     op = int'(opSel);
    longint sA, sY, sv, uA, uY, uv;
    logic [31:0] bv, yv;
    bit     isSub, cinv, doCode;
    int     kind;
    logic [3:0] cd;
    doCode = 0;
    cd = 4'b0;
    if (!valid || op > 12) begin
      mResValid = 0;
      flagTag = "R12";
      return;
    end
    if (op == 12) begin
      mSo = 0; mOv = 0; mCa = 0;
      mResValid = 0;
      flagTag = "R10";
      return;
    end
    if (op == 11) bv = useImm ? {16'h0, imm} : opB;
    else          bv = useImm ? {{16{imm[15]}}, imm} : opB;
    if (op <= 9) begin
      isSub = (op >= 5);
      kind  = op % 5;
      yv    = (kind <= 2) ? bv : ((kind == 3) ? 32'hFFFF_FFFF : 32'h0);
      cinv  = (kind <= 1) ? isSub : mCa;
      sA = longint'($signed(opA)); sY = longint'($signed(yv));
      uA = longint'(opA);          uY = longint'(yv);
      if (isSub) begin
        sv = sY - sA - 1 + longint'(cinv);
        uv = uY + (64'hFFFF_FFFF - uA) + longint'(cinv);
      end else begin
        sv = sA + sY + longint'(cinv);
        uv = uA + uY + longint'(cinv);
      end
      mRes = uv[31:0];
      if (kind != 0) mCa = (uv >= 64'h1_0000_0000);
      if (ovEnable) begin
        mOv = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        if (mOv) mSo = 1;
      end
      cd = codeOf(longint'($signed(mRes)));
      flagTag = (kind == 0) ? "R5" : (ovEnable ? "R6" : "R4");
    end else begin
      if (op == 10) cd = codeOf(longint'($signed(opA)) - longint'($signed(bv)));
      else          cd = codeOf(longint'(opA) - longint'(bv));
      mRes = {28'h0, cd};
      flagTag = "R8";
    end
    doCode = 1;
    mResValid = 1;
    if (recEnable && doCode) mCond = {cd[3:1], mSo};
  endtask

  task automatic step(string rtag);
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    check(result === mRes, rtag, result, mRes);
    check(resValid === mResValid, "R13", {31'h0, resValid}, {31'h0, mResValid});
    check(flagWord === {mSo, mOv, mCa, 1'b0}, flagTag, {28'h0, flagWord}, {28'h0, mSo, mOv, mCa, 1'b0});
    check(condField === mCond, "R9", {28'h0, condField}, {28'h0, mCond});
  endtask

  task automatic issue(int op, logic [31:0] a, logic [31:0] b, logic [15:0] im,
                       bit ui, bit ov, bit rc);
    valid = 1'b1; opSel = 4'(op); opA = a; opB = b; imm = im;
    useImm = ui; ovEnable = ov; recEnable = rc;
    step(resTag(op));
    valid = 1'b0;
  endtask

  initial begin
    #(2_000_000);
    testsRun++;
    testsFailed++;
    $display("FAIL R13 watchdog actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(result === 32'h0 && resValid === 1'b0, "R1", result, 32'h0);
    check(flagWord === 4'h0 && condField === 4'h0, "R1", {24'h0, flagWord, condField}, 32'h0);
    rst = 1'b0;

    // R6: signed overflow with recording; cond low bit carries SO
    issue(0, 32'h7FFF_FFFF, 32'h1, 16'h0, 0, 1, 1);
    check(condField === 4'b1001, "R9", {28'h0, condField}, 32'h9);
    // R7: no overflow clears OV, SO stays
    issue(0, 32'h1, 32'h1, 16'h0, 0, 1, 0);
    check(flagWord === 4'b1000, "R7", {28'h0, flagWord}, 32'h8);
    // R10: clear
    issue(12, 32'h0, 32'h0, 16'h0, 0, 1, 1);
    check(flagWord === 4'b0000, "R10", {28'h0, flagWord}, 32'h0);
    // R3: 5 - 3, no borrow sets carry
    issue(6, 32'd3, 32'd5, 16'h0, 0, 0, 0);
    check(result === 32'd2 && flagWord[1] === 1'b1, "R3", result, 32'd2);
    // R4: extended add uses stored carry 1
    issue(2, 32'd10, 32'd20, 16'h0, 0, 0, 0);
    check(result === 32'd31, "R4", result, 32'd31);
    // R11: immediate extension differs between signed and unsigned compare
    issue(10, 32'd1, 32'h0, 16'hFFFF, 1, 0, 1);
    check(result === 32'h4, "R11", result, 32'h4);
    issue(11, 32'd1, 32'h0, 16'hFFFF, 1, 0, 1);
    check(result === 32'h8, "R11", result, 32'h8);
    // R12: idle cycles and unused opcodes with junk operands
    opA = 32'hDEAD_BEEF; ovEnable = 1; recEnable = 1; opSel = 4'd0;
    step("R12");
    issue(13, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0, 0, 1, 1);
    issue(15, 32'h1, 32'h2, 16'h0, 0, 1, 1);

    // corner sweep of every opcode
    for (int op = 0; op < 13; op++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          for (int m = 0; m < 4; m++) begin
            issue(op, corners[i], corners[j], 16'h0, 0, m[0], m[1]);
          end
        end
      end
    end

    // random operands, immediates and controls
    for (int k = 0; k < 3000; k++) begin
      int rop = int'($urandom_range(0, 15));
      if (rop == 12 && ($urandom_range(0, 3) != 0)) rop = 1;
      issue(rop, $urandom, ($urandom_range(0, 3) == 0) ? corners[$urandom_range(0, 4)] : $urandom,
            16'($urandom), $urandom_range(0, 3) == 0, 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 7) == 0) step("R12");
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule